// File: doc/BRIEF.md
# Link Bring-up and Poll Controller

This block is a hardware sequencer that takes a PCIe root port from reset to a trained link. Once the reset-release input is seen high, it writes a fixed series of control settings into a small register file, one setting per clock. The settings are direct access mode, the root-complex role, the ECRC error-capability enables, the speed generation, the lane count, the training enable and the address-window mapping enable. It then issues a one-cycle retrain request.

After the retrain request it watches the 6-bit link-state code, which stands in for the real training state machine and PHY. It samples that code at a fixed interval for a bounded number of tries. When a sample shows a trained link, the block raises link_up and, one clock later, opens the command enables. When every try fails, it raises link_fail, and the command enables stay shut until the next reset.

Top module: `lnk_bringup_ctrl`

## Requirements
- R1: While reset is asserted, every output is zero.
- R2: Nothing is written until release_i is seen high. After the clock edge that sees it, the writes land on the next eight consecutive edges, in this order: direct mode (`direct_o`), root-complex flag, ECRC enables, speed, lane count, training enable, window mapping, retrain request.
- R3: The final control word has speed in bits [1:0] equal to SPEED_SEL (0 = Gen1, 1 = Gen2, 2 = Gen3; default Gen2), the root-complex flag in bit 2, the lane count in bits [4:3] equal to LANE_SEL (x1, x2, x4, x8 as 0 to 3; default x1) and training enable in bit 6. With the defaults this gives 0x45. `ctrl2_o` bit 6 is window mapping, giving 0x40. All four ECRC enable bits are set, so `ecrc_o` is 0xF.
- R4: `retrain_o` is high for exactly one cycle per bring-up.
- R5: A sample counts as link-up when `ltssm_i` is at or above 0x10. A value of 0x0F or lower is not link-up.
- R6: The first sample is taken on the edge after the retrain edge. Later samples follow every POLL_WAIT+1 cycles, and the link state is looked at on no other edge.
- R7: At most MAX_TRIES samples are taken. If the last one fails, `link_fail_o` rises on that sample edge.
- R8: `cmd_en_o` becomes 3'b111 one cycle after `link_up_o` rises. Bit 0 is I/O, bit 1 is memory and bit 2 is bus master. After a timeout it stays 0.
- R9: `link_up_o` and `link_fail_o` are never high together. Each stays high until reset, whatever `ltssm_i` and `release_i` do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| release_i | input | 1 | Reset-release request that starts bring-up |
| ltssm_i | input | LTSSM_W | Current link training state code |
| direct_o | output | 1 | Direct access mode selected |
| ctrl0_o | output | CTRL_W | Core control word (speed, role, lanes, training) |
| ctrl2_o | output | CTRL_W | Second control word (window mapping) |
| ecrc_o | output | 4 | ECRC generate/check enables |
| retrain_o | output | 1 | One-cycle retrain request |
| link_up_o | output | 1 | Trained link detected (sticky) |
| link_fail_o | output | 1 | All tries exhausted (sticky) |
| cmd_en_o | output | 3 | Command enables: I/O, memory, bus master |

## Verification
On every cycle, the embedded properties check the following:
- the retrain pulse is a single cycle;
- link_up and link_fail are exclusive and sticky;
- the command enables are gated on link-up;
- a rise of link_up always follows a link code at or above the threshold.

Only the bench scenarios can show when each write lands, on which edges the samples fall and how many tries come before the timeout. To do that, the bench sweeps the edge at which the link code crosses the threshold over every sample slot, uses link codes just below and above 0x10, and runs a case where no try succeeds.

// File: rtl/lnk_bringup_pkg.sv
package lnk_bringup_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DIRECT,
      ST_ROOT,
      ST_ECRC,
      ST_SPEED,
      ST_LANES,
      ST_TRAIN,
      ST_WINMAP,
      ST_RETRAIN,
      ST_POLL,
      ST_WAIT,
      ST_LINKUP,
      ST_DONE,
      ST_FAIL
   } seq_state_e;

   // Field positions decoded by the core behind this block
   localparam int SPD_LSB    = 0;
   localparam int ROOT_BIT   = 2;
   localparam int LANE_LSB   = 3;
   localparam int TRAIN_BIT  = 6;
   localparam int WINMAP_BIT = 6;

   typedef struct packed {
      logic direct;
      logic root;
      logic ecrc;
      logic speed;
      logic lanes;
      logic train;
      logic winmap;
      logic retrain;
      logic up;
      logic fail;
      logic cmd;
   } reg_stb_t;

endpackage

// File: rtl/lnk_state_cmp.sv
module lnk_state_cmp #(
   parameter int LTSSM_W = 6,
   parameter int UP_CODE = 16
) (
   input  logic [LTSSM_W-1:0] ltssm_i,
   output logic               at_l0_o
);
   localparam logic [LTSSM_W-1:0] UP_VAL = LTSSM_W'(UP_CODE);

   if (UP_CODE >= (1 << LTSSM_W)) begin : g_bad_code
      $error("UP_CODE does not fit in LTSSM_W bits");
   end

   if (UP_CODE == 0) begin : g_always_up
      assign at_l0_o = 1'b1;
   end else begin : g_threshold
      assign at_l0_o = (ltssm_i >= UP_VAL);
   end
endmodule

// File: rtl/lnk_poll_timer.sv
module lnk_poll_timer #(
   parameter int POLL_WAIT = 1000,
   parameter int MAX_TRIES = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic tick_i,
   input  logic try_i,
   output logic wait_done_o,
   output logic last_try_o
);
   localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES + 1) : 1;

   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("MAX_TRIES must be at least 1");
   end
   if (POLL_WAIT < 0) begin : g_bad_wait
      $error("POLL_WAIT must not be negative");
   end

   logic [TRY_W-1:0] tries_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tries_q <= '0;
      end else if (try_i) begin
         tries_q <= tries_q + 1'b1;
      end
   end

   assign last_try_o = (tries_q == TRY_W'(MAX_TRIES - 1));

   p_try_bound_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      tries_q <= TRY_W'(MAX_TRIES));

   if (POLL_WAIT == 0) begin : g_no_wait
      assign wait_done_o = 1'b1;
   end else begin : g_wait_cnt
      localparam int WAIT_W = $clog2(POLL_WAIT + 1);
      logic [WAIT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (load_i) begin
            cnt_q <= WAIT_W'(POLL_WAIT - 1);
         end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign wait_done_o = (cnt_q == '0);

      p_wait_bound_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         cnt_q <= WAIT_W'(POLL_WAIT - 1));
   end
endmodule

// File: rtl/lnk_seq_fsm.sv
module lnk_seq_fsm
   import lnk_bringup_pkg::*;
#(
   parameter int POLL_WAIT = 1000
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     release_i,
   input  logic     at_l0_i,
   input  logic     wait_done_i,
   input  logic     last_try_i,
   output reg_stb_t stb_o,
   output logic     try_o,
   output logic     load_o,
   output logic     tick_o
);
   seq_state_e state_q, state_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (release_i) state_d = ST_DIRECT;
         ST_DIRECT:  state_d = ST_ROOT;
         ST_ROOT:    state_d = ST_ECRC;
         ST_ECRC:    state_d = ST_SPEED;
         ST_SPEED:   state_d = ST_LANES;
         ST_LANES:   state_d = ST_TRAIN;
         ST_TRAIN:   state_d = ST_WINMAP;
         ST_WINMAP:  state_d = ST_RETRAIN;
         ST_RETRAIN: state_d = ST_POLL;
         ST_POLL: begin
            if (at_l0_i)             state_d = ST_LINKUP;
            else if (last_try_i)     state_d = ST_FAIL;
            else if (POLL_WAIT == 0) state_d = ST_POLL;
            else                     state_d = ST_WAIT;
         end
         ST_WAIT:    if (wait_done_i) state_d = ST_POLL;
         ST_LINKUP:  state_d = ST_DONE;
         ST_DONE:    state_d = ST_DONE;
         ST_FAIL:    state_d = ST_FAIL;
         default:    state_d = ST_IDLE;
      endcase
   end

   logic polling, miss;
   assign polling = (state_q == ST_POLL);
   assign miss    = polling && !at_l0_i;

   always_comb begin
      stb_o         = '0;
      stb_o.direct  = (state_q == ST_DIRECT);
      stb_o.root    = (state_q == ST_ROOT);
      stb_o.ecrc    = (state_q == ST_ECRC);
      stb_o.speed   = (state_q == ST_SPEED);
      stb_o.lanes   = (state_q == ST_LANES);
      stb_o.train   = (state_q == ST_TRAIN);
      stb_o.winmap  = (state_q == ST_WINMAP);
      stb_o.retrain = (state_q == ST_RETRAIN);
      stb_o.up      = polling && at_l0_i;
      stb_o.fail    = miss && last_try_i;
      stb_o.cmd     = (state_q == ST_LINKUP);
   end

   assign try_o  = miss;
   assign load_o = miss && !last_try_i;
   assign tick_o = (state_q == ST_WAIT);

   p_fail_terminal_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FAIL) |=> (state_q == ST_FAIL));
   p_done_terminal_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DONE) |=> (state_q == ST_DONE));
endmodule

// File: rtl/lnk_ctrl_regs.sv
module lnk_ctrl_regs
   import lnk_bringup_pkg::*;
#(
   parameter int CTRL_W    = 8,
   parameter int SPEED_SEL = 1,
   parameter int LANE_SEL  = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  reg_stb_t          stb_i,
   output logic              direct_o,
   output logic [CTRL_W-1:0] ctrl0_o,
   output logic [CTRL_W-1:0] ctrl2_o,
   output logic [3:0]        ecrc_o,
   output logic              retrain_o,
   output logic              link_up_o,
   output logic              link_fail_o,
   output logic [2:0]        cmd_en_o
);
   if (CTRL_W < TRAIN_BIT + 1) begin : g_bad_width
      $error("CTRL_W too narrow for the training bit");
   end
   if (SPEED_SEL < 0 || SPEED_SEL > 2) begin : g_bad_speed
      $error("SPEED_SEL must be 0, 1 or 2");
   end
   if (LANE_SEL < 0 || LANE_SEL > 3) begin : g_bad_lane
      $error("LANE_SEL must be 0 to 3");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         direct_o    <= 1'b0;
         ctrl0_o     <= '0;
         ctrl2_o     <= '0;
         ecrc_o      <= '0;
         retrain_o   <= 1'b0;
         link_up_o   <= 1'b0;
         link_fail_o <= 1'b0;
         cmd_en_o    <= '0;
      end else begin
         retrain_o <= stb_i.retrain;
         if (stb_i.direct) direct_o                  <= 1'b1;
         if (stb_i.root)   ctrl0_o[ROOT_BIT]         <= 1'b1;
         if (stb_i.ecrc)   ecrc_o                    <= 4'hF;
         if (stb_i.speed)  ctrl0_o[SPD_LSB +: 2]     <= 2'(SPEED_SEL);
         if (stb_i.lanes)  ctrl0_o[LANE_LSB +: 2]    <= 2'(LANE_SEL);
         if (stb_i.train)  ctrl0_o[TRAIN_BIT]        <= 1'b1;
         if (stb_i.winmap) ctrl2_o[WINMAP_BIT]       <= 1'b1;
         if (stb_i.up)     link_up_o                 <= 1'b1;
         if (stb_i.fail)   link_fail_o               <= 1'b1;
         if (stb_i.cmd)    cmd_en_o                  <= 3'b111;
      end
   end

   p_retrain_pulse_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      retrain_o |=> !retrain_o);
   p_retrain_after_win_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      retrain_o |-> (ctrl2_o[WINMAP_BIT] && ctrl0_o[TRAIN_BIT]));
   p_train_after_root_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctrl0_o[TRAIN_BIT]) |-> (ctrl0_o[ROOT_BIT] && direct_o && (ecrc_o == 4'hF)));
   p_cmd_gated_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_en_o != 3'b000) |-> (link_up_o && !link_fail_o));
   p_cmd_late_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cmd_en_o[0]) |-> $past(link_up_o));
   p_exclusive_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(link_up_o && link_fail_o));
   p_up_sticky_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_up_o |=> link_up_o);
   p_fail_sticky_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_fail_o |=> (link_fail_o && (cmd_en_o == 3'b000)));
endmodule

// File: rtl/lnk_bringup_ctrl.sv
module lnk_bringup_ctrl
   import lnk_bringup_pkg::*;
#(
   parameter int LTSSM_W   = 6,
   parameter int UP_CODE   = 16,
   parameter int POLL_WAIT = 1000,
   parameter int MAX_TRIES = 10,
   parameter int CTRL_W    = 8,
   parameter int SPEED_SEL = 1,
   parameter int LANE_SEL  = 0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               release_i,
   input  logic [LTSSM_W-1:0] ltssm_i,
   output logic               direct_o,
   output logic [CTRL_W-1:0]  ctrl0_o,
   output logic [CTRL_W-1:0]  ctrl2_o,
   output logic [3:0]         ecrc_o,
   output logic               retrain_o,
   output logic               link_up_o,
   output logic               link_fail_o,
   output logic [2:0]         cmd_en_o
);
   localparam logic [LTSSM_W-1:0] UP_VAL = LTSSM_W'(UP_CODE);

   logic     at_l0, wait_done, last_try, try_s, load_s, tick_s;
   reg_stb_t stb;

   lnk_state_cmp #(.LTSSM_W(LTSSM_W), .UP_CODE(UP_CODE)) u_cmp (
      .ltssm_i (ltssm_i),
      .at_l0_o (at_l0)
   );

   lnk_poll_timer #(.POLL_WAIT(POLL_WAIT), .MAX_TRIES(MAX_TRIES)) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_s),
      .tick_i      (tick_s),
      .try_i       (try_s),
      .wait_done_o (wait_done),
      .last_try_o  (last_try)
   );

   lnk_seq_fsm #(.POLL_WAIT(POLL_WAIT)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .release_i   (release_i),
      .at_l0_i     (at_l0),
      .wait_done_i (wait_done),
      .last_try_i  (last_try),
      .stb_o       (stb),
      .try_o       (try_s),
      .load_o      (load_s),
      .tick_o      (tick_s)
   );

   lnk_ctrl_regs #(.CTRL_W(CTRL_W), .SPEED_SEL(SPEED_SEL), .LANE_SEL(LANE_SEL)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stb_i       (stb),
      .direct_o    (direct_o),
      .ctrl0_o     (ctrl0_o),
      .ctrl2_o     (ctrl2_o),
      .ecrc_o      (ecrc_o),
      .retrain_o   (retrain_o),
      .link_up_o   (link_up_o),
      .link_fail_o (link_fail_o),
      .cmd_en_o    (cmd_en_o)
   );

   p_up_threshold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(link_up_o) |-> ($past(ltssm_i) >= UP_VAL));
   p_fail_below_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(link_fail_o) |-> ($past(ltssm_i) < UP_VAL));
endmodule

// File: tb/lnk_bringup_ctrl_bench.sv
module lnk_bringup_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WAITC      = 3;
   localparam int  TRIES      = 10;
   localparam int  HORIZON    = 60;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       release_s;
   logic [5:0] ltssm;
   logic       direct;
   logic [7:0] ctrl0, ctrl2;
   logic [3:0] ecrc;
   logic       retrain, up, fail;
   logic [2:0] cmd;
   logic [26:0] outs;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign outs = {direct, ctrl0, ctrl2, ecrc, retrain, up, fail, cmd};

   lnk_bringup_ctrl #(.POLL_WAIT(WAITC), .MAX_TRIES(TRIES)) u_lnk_bringup_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .release_i   (release_s),
      .ltssm_i     (ltssm),
      .direct_o    (direct),
      .ctrl0_o     (ctrl0),
      .ctrl2_o     (ctrl2),
      .ecrc_o      (ecrc),
      .retrain_o   (retrain),
      .link_up_o   (up),
      .link_fail_o (fail),
      .cmd_en_o    (cmd)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sample_edge(input int k);
      return 9 + k * (WAITC + 1);
   endfunction

   // k < 0: the link never comes up
   task automatic run_case(input int k, input logic [5:0] lo, input logic [5:0] hi);
      int ed_dir = -1, ed_root = -1, ed_ecrc = -1, ed_spd = -1, ed_trn = -1;
      int ed_win = -1, ed_rt = -1, ed_up = -1, ed_fail = -1, ed_cmd = -1;
      int rt_cnt = 0;
      rst_n = 1'b0; release_s = 1'b0; ltssm = lo;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset outputs", int'(outs), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2 idle without release", int'(outs), 0);
      release_s = 1'b1;
      @(posedge clk);
      for (int e = 1; e <= HORIZON; e++) begin
         @(posedge clk);
         #1;
         if (k >= 0 && e == sample_edge(k) - 1 - (k % 3)) ltssm = hi;
         if (k >= 0 && e == sample_edge(k) + 2) ltssm = lo;
         if (e == 20) release_s = 1'b0;
         if (e == 30) release_s = 1'b1;
         @(negedge clk);
         if (ed_dir  < 0 && direct)          ed_dir  = e;
         if (ed_root < 0 && ctrl0[2])        ed_root = e;
         if (ed_ecrc < 0 && ecrc != 4'h0)    ed_ecrc = e;
         if (ed_spd  < 0 && ctrl0[1:0] != 0) ed_spd  = e;
         if (ed_trn  < 0 && ctrl0[6])        ed_trn  = e;
         if (ed_win  < 0 && ctrl2[6])        ed_win  = e;
         if (retrain) begin
            rt_cnt++;
            if (ed_rt < 0) ed_rt = e;
         end
         if (ed_up   < 0 && up)              ed_up   = e;
         if (ed_fail < 0 && fail)            ed_fail = e;
         if (ed_cmd  < 0 && cmd != 3'b000)   ed_cmd  = e;
      end
      chk("R2 direct mode edge", ed_dir, 1);
      chk("R2 root flag edge", ed_root, 2);
      chk("R2 ecrc edge", ed_ecrc, 3);
      chk("R2 speed edge", ed_spd, 4);
      chk("R2 training enable edge", ed_trn, 6);
      chk("R2 window map edge", ed_win, 7);
      chk("R4 retrain edge", ed_rt, 8);
      chk("R4 retrain pulse count", rt_cnt, 1);
      chk("R3 ctrl0 value", int'(ctrl0), 'h45);
      chk("R3 lane field x1", int'(ctrl0[4:3]), 0);
      chk("R3 ctrl2 value", int'(ctrl2), 'h40);
      chk("R3 ecrc value", int'(ecrc), 'hF);
      if (k >= 0) begin
         chk("R5 R6 link_up sample edge", ed_up, sample_edge(k));
         chk("R8 cmd enable edge", ed_cmd, sample_edge(k) + 1);
         chk("R8 cmd enable value", int'(cmd), 7);
         chk("R7 no timeout", ed_fail, -1);
         chk("R9 link_up held", int'(up), 1);
      end else begin
         chk("R7 timeout edge", ed_fail, sample_edge(TRIES - 1));
         chk("R8 cmd stays clear", ed_cmd, -1);
         chk("R9 no link_up after fail", ed_up, -1);
         chk("R9 link_fail held", int'(fail), 1);
      end
   endtask

   initial begin
      logic [5:0] hi_tab [4] = '{6'h10, 6'h11, 6'h2A, 6'h3F};
      logic [5:0] lo_tab [4] = '{6'h0F, 6'h00, 6'h07, 6'h0C};
      for (int k = 0; k < TRIES; k++) run_case(k, lo_tab[k % 4], hi_tab[k % 4]);
      run_case(-1, 6'h0F, 6'h0F);
      run_case(-1, 6'h00, 6'h00);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule